// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that software keeps alive through a small byte/halfword register port. A down-counter loads a chosen timeout length and decrements on every tick of a programmable prescaler. The counter is started or reloaded only by a two-byte unlock pattern written to the refresh register. While the counter runs, a refresh is accepted only when the live count lies inside a window. The window's upper and lower limits are set as quarters of the timeout period.

A refresh outside the window sets a refresh-error flag. A counter that reaches zero on a tick sets an underflow flag. Either flag drives one of two outputs, an interrupt request or a reset request, as chosen by a single action bit. The output stays high until software clears the flags. The configuration and action registers can each be written once, and only before the first refresh. After that they are frozen until reset.

Top module: `win_watchdog`

## Requirements
- R1: After reset the configuration register reads 0x3303, the action register reads 0x80, the status register reads 0x0000, the refresh register reads 0x00, and both outputs are low.
- R2: The counter starts, or reloads, only when a byte write of 0x00 to offset 0x00 is followed by a byte write of 0xFF to offset 0x00. Any other byte written to offset 0x00 between them cancels the pattern. A read of offset 0x00 returns the counter's eight most significant bits (bits 13:6).
- R3: Configuration bits [1:0] select the timeout in ticks: 00 gives 1024, 01 gives 4096, 10 gives 8192 and 11 gives 16384. A refresh loads the period minus one.
- R4: Configuration bits [7:4] select the clock cycles per tick: 0000 gives 1, 0001 gives 4, 0010 gives 16, 0011 gives 32, 0100 gives 64, 1111 gives 128 and 0101 gives 256. Every other code gives 1.
- R5: A refresh that completes while the counter runs sets status bit 1 if the count is above the upper limit or below the lower limit. Configuration bits [13:12] = c set the upper limit to (c+1)/4 of the period. Bits [9:8] = e set the lower limit to (3-e)/4 of the period. A refresh that starts a stopped counter never sets status bit 1.
- R6: A tick that finds the count at zero sets status bit 0 and stops the counter.
- R7: While either status flag is set, action bit 7 = 1 raises rst_req_o and action bit 7 = 0 raises irq_o. The two outputs are never high together.
- R8: A halfword write to offset 0x04 clears each flag whose data bit (bit 0 for underflow, bit 1 for refresh error) is 0. A flag being set in the same cycle wins over the clear.
- R9: The configuration register (0x02) and the action register (0x06) each accept only their first write, and only before the first completed refresh. Every later write is ignored.
- R10: Configuration and status writes take effect only with bus_size = 1 (halfword). Refresh and action writes take effect only with bus_size = 0 (byte). A write of the wrong size is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 16 | Write data (bytes use bits 7:0) |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_size | input | 1 | 0 byte access, 1 halfword access |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt request on a pending error |
| rst_req_o | output | 1 | Reset request on a pending error |

## Verification
The window check is driven from a vector table. Each vector places the second refresh at a different delay after the first: far too early, one tick above and exactly at the upper limit, the middle of the window, and exactly at and one tick below the lower limit. These vectors pin the comparison edges to single counts, and the action bit alternates between them so that both outputs are exercised. Separate underflow runs use three settings: a 4096-tick period, a divide-by-4 prescaler, and an undefined prescaler code. These runs show whether the period and the tick rate are decoded independently. Directed cases cover a broken unlock pattern, wrong-size writes, and writes after the configuration is frozen.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
// Shared constants and decode helpers for the windowed watchdog.
// Assumes byte offsets on a 3-bit address and 16-bit data.
package wdt_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] OFS_KICK = 3'h0;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 3'h2;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'h4;
    localparam logic [ADDR_W-1:0] OFS_ACT  = 3'h6;

    localparam logic [7:0] KICK_ARM  = 8'h00;
    localparam logic [7:0] KICK_FIRE = 8'hFF;

    // Configuration register layout
    typedef struct packed {
        logic [1:0] rsv_hi;
        logic [1:0] open_sel;   // upper window limit
        logic [1:0] rsv_mid;
        logic [1:0] close_sel;  // lower window limit
        logic [3:0] div_sel;    // prescaler ratio
        logic [1:0] rsv_lo;
        logic [1:0] len_sel;    // timeout length
    } cfg_t;

    localparam cfg_t CFG_RESET = 16'h3303;
    localparam logic [7:0] ACT_RESET = 8'h80;

    // Clock cycles per counter tick for a divider code
    function automatic int unsigned div_ratio(input logic [3:0] sel);
        case (sel)
            4'b0001: return 4;
            4'b0010: return 16;
            4'b0011: return 32;
            4'b0100: return 64;
            4'b0101: return 256;
            4'b1111: return 128;
            default: return 1;
        endcase
    endfunction
endpackage

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
// Tick generator: one tick every div_ratio(div_sel_i) cycles while running.
// Assumes PRESC_W holds the largest ratio minus one; restarts on refresh.
module wdt_prescaler #(
    parameter int PRESC_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       restart_i,
    input  logic [3:0] div_sel_i,
    output logic       tick_o
);
    logic [PRESC_W-1:0] phase_q;
    logic [PRESC_W-1:0] limit;

    // Terminal phase for the selected ratio
    always_comb limit = PRESC_W'(wdt_pkg::div_ratio(div_sel_i) - 1);

    assign tick_o = run_i && (phase_q == limit);

    // Phase counter, held at zero when idle or restarted
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !run_i || tick_o)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
// Down-counter with window comparison and underflow detection.
// Assumes the period field is stable while running (frozen by the lock).
module wdt_counter #(
    parameter int BASE_LEN = 1024,
    parameter int CNT_W    = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       kick_i,
    input  logic [1:0] len_sel_i,
    input  logic [1:0] open_sel_i,
    input  logic [1:0] close_sel_i,
    output logic       run_o,
    output logic [7:0] view_o,
    output logic       uf_set_o,
    output logic       re_set_o
);
    localparam int LEN_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [LEN_W-1:0] period, quarter, open_lim, close_lim, cnt_ext;
    logic             outside;

    // Period for the selected length code
    always_comb begin
        case (len_sel_i)
            2'b00:   period = LEN_W'(BASE_LEN);
            2'b01:   period = LEN_W'(BASE_LEN * 4);
            2'b10:   period = LEN_W'(BASE_LEN * 8);
            default: period = LEN_W'(BASE_LEN * 16);
        endcase
    end

    // Window limits in quarters of the period
    always_comb begin
        quarter = period >> 2;
        case (open_sel_i)
            2'b00:   open_lim = quarter;
            2'b01:   open_lim = quarter << 1;
            2'b10:   open_lim = quarter + (quarter << 1);
            default: open_lim = period;
        endcase
        case (close_sel_i)
            2'b00:   close_lim = quarter + (quarter << 1);
            2'b01:   close_lim = quarter << 1;
            2'b10:   close_lim = quarter;
            default: close_lim = '0;
        endcase
        cnt_ext = {1'b0, cnt_q};
        outside = (cnt_ext > open_lim) || (cnt_ext < close_lim);
    end

    assign uf_set_o = tick_i && !kick_i && (cnt_q == '0);
    assign re_set_o = kick_i && run_q && outside;
    assign run_o    = run_q;
    assign view_o   = cnt_q[CNT_W-1 -: 8];

    // Reload on refresh, decrement per tick, stop on underflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (kick_i) begin
            cnt_q <= CNT_W'(period - 1'b1);
            run_q <= 1'b1;
        end else if (tick_i) begin
            if (cnt_q == '0)
                run_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
// Register file: unlock-pattern detection, write-once locks, status flags
// and read mux. Assumes one-cycle write strobes and a combinational read.
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_size,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [7:0]        view_i,
    input  logic              uf_set_i,
    input  logic              re_set_i,
    output logic              kick_o,
    output cfg_t              cfg_o,
    output logic              act_rst_o,
    output logic              uf_o,
    output logic              re_o,
    output logic              cfg_lock_o
);
    cfg_t       cfg_q;
    logic [7:0] act_q;
    logic       armed_q, cfg_lock_q, act_lock_q, uf_q, re_q;
    logic       wr_byte, wr_half, kick_wr, cfg_wr, act_wr, stat_wr;

    // Decode of accepted writes
    always_comb begin
        wr_byte = bus_we && !bus_size;
        wr_half = bus_we &&  bus_size;
        kick_wr = wr_byte && (bus_addr == OFS_KICK);
        cfg_wr  = wr_half && (bus_addr == OFS_CFG) && !cfg_lock_q;
        act_wr  = wr_byte && (bus_addr == OFS_ACT) && !act_lock_q;
        stat_wr = wr_half && (bus_addr == OFS_STAT);
        kick_o  = kick_wr && armed_q && (bus_wdata[7:0] == KICK_FIRE);
    end

    // Unlock-pattern tracking: arm on 00h, drop on any other byte
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (kick_wr) armed_q <= (bus_wdata[7:0] == KICK_ARM);
    end

    // Write-once configuration and action registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= CFG_RESET;
            act_q      <= ACT_RESET;
            cfg_lock_q <= 1'b0;
            act_lock_q <= 1'b0;
        end else begin
            if (cfg_wr) cfg_q <= bus_wdata;
            if (act_wr) act_q <= bus_wdata[7:0];
            cfg_lock_q <= cfg_lock_q | cfg_wr | kick_o;
            act_lock_q <= act_lock_q | act_wr | kick_o;
        end
    end

    // Error flags: set wins, cleared by writing zero to the bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_q <= 1'b0;
            re_q <= 1'b0;
        end else begin
            uf_q <= uf_set_i | (uf_q & ~(stat_wr & ~bus_wdata[0]));
            re_q <= re_set_i | (re_q & ~(stat_wr & ~bus_wdata[1]));
        end
    end

    // Read mux
    always_comb begin
        case (bus_addr)
            OFS_KICK: bus_rdata = {8'h00, view_i};
            OFS_CFG:  bus_rdata = cfg_q;
            OFS_STAT: bus_rdata = {14'h0, re_q, uf_q};
            OFS_ACT:  bus_rdata = {8'h00, act_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign cfg_o      = cfg_q;
    assign act_rst_o  = act_q[7];
    assign uf_o       = uf_q;
    assign re_o       = re_q;
    assign cfg_lock_o = cfg_lock_q;
endmodule

// File: rtl/win_watchdog.sv
`timescale 1ns/1ps
// Windowed watchdog top: register file, prescaler and counter.
// Assumes a synchronous active-low reset and single-cycle bus writes.
module win_watchdog #(
    parameter int BASE_LEN = 1024,
    parameter int PRESC_W  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_we,
    input  logic        bus_size,
    output logic [15:0] bus_rdata,
    output logic        irq_o,
    output logic        rst_req_o
);
    localparam int CNT_W = $clog2(BASE_LEN * 16);

    wdt_pkg::cfg_t cfg_q;
    logic       kick, tick, running, act_rst;
    logic       uf_flag, re_flag, uf_set, re_set, cfg_lock;
    logic [7:0] view;

    wdt_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_size   (bus_size),
        .bus_rdata  (bus_rdata),
        .view_i     (view),
        .uf_set_i   (uf_set),
        .re_set_i   (re_set),
        .kick_o     (kick),
        .cfg_o      (cfg_q),
        .act_rst_o  (act_rst),
        .uf_o       (uf_flag),
        .re_o       (re_flag),
        .cfg_lock_o (cfg_lock)
    );

    wdt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (running),
        .restart_i (kick),
        .div_sel_i (cfg_q.div_sel),
        .tick_o    (tick)
    );

    wdt_counter #(.BASE_LEN(BASE_LEN), .CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .kick_i      (kick),
        .len_sel_i   (cfg_q.len_sel),
        .open_sel_i  (cfg_q.open_sel),
        .close_sel_i (cfg_q.close_sel),
        .run_o       (running),
        .view_o      (view),
        .uf_set_o    (uf_set),
        .re_set_o    (re_set)
    );

    // Error routing to the selected request line
    always_comb begin
        irq_o     = (uf_flag || re_flag) && !act_rst;
        rst_req_o = (uf_flag || re_flag) &&  act_rst;
    end
endmodule

// File: rtl/wdt_chk.sv
`timescale 1ns/1ps
// Property checker for win_watchdog, attached by bind.
module wdt_chk (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_o,
    input logic          rst_req_o,
    input logic          uf_flag,
    input logic          re_flag,
    input logic          uf_set,
    input logic          re_set,
    input logic          cfg_lock,
    input wdt_pkg::cfg_t cfg_q
);
    // R7
    out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && rst_req_o));
    // R7
    out_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || rst_req_o) |-> (uf_flag || re_flag));
    // R6
    uf_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_set |=> uf_flag);
    // R5
    re_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        re_set |=> re_flag);
    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> $stable(cfg_q));
endmodule

bind win_watchdog wdt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o),
    .uf_flag   (uf_flag),
    .re_flag   (re_flag),
    .uf_set    (uf_set),
    .re_set    (re_set),
    .cfg_lock  (cfg_lock),
    .cfg_q     (cfg_q)
);

// File: tb/tb_win_watchdog.sv
`timescale 1ns/1ps
module tb_win_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_size = 1'b0;
    logic [15:0] bus_rdata;
    logic        irq_o, rst_req_o;
    int n_chk = 0;
    int n_fail = 0;

    win_watchdog dut (.*);

    always #4 clk = ~clk;

    // {gap cycles[15:0], expect error[7:0], action byte[7:0]}
    // window config 0x2200: period 1024, upper 768, lower 256
    localparam logic [31:0] VEC [6] = '{
        {16'd0,   8'd1, 8'h00},
        {16'd251, 8'd1, 8'h80},
        {16'd252, 8'd0, 8'h00},
        {16'd500, 8'd0, 8'h80},
        {16'd764, 8'd0, 8'h00},
        {16'd765, 8'd1, 8'h80}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic sz);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic kick();
        wr(3'h0, 16'h0000, 1'b0);
        wr(3'h0, 16'h00FF, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Underflow timing: outputs quiet one cycle early, raised at the tick
    task automatic underflow_run(input string req, input int cycles, input logic use_rst);
        logic [15:0] d;
        repeat (cycles - 1) @(negedge clk);
        check({req, " before underflow"}, {14'h0, irq_o, rst_req_o}, 16'h0);
        @(negedge clk);
        check({req, " at underflow"}, {14'h0, irq_o, rst_req_o},
              use_rst ? 16'h1 : 16'h2);
        rd(3'h4, d);
        check("R6 underflow flag", d, 16'h0001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        do_reset();

        // R1 reset state
        rd(3'h2, d); check("R1 cfg reset", d, 16'h3303);
        rd(3'h6, d); check("R1 act reset", d, 16'h0080);
        rd(3'h4, d); check("R1 status reset", d, 16'h0000);
        rd(3'h0, d); check("R1 counter idle", d, 16'h0000);
        check("R1 outputs", {14'h0, irq_o, rst_req_o}, 16'h0);

        // R10 wrong-size writes ignored
        wr(3'h2, 16'h1111, 1'b0);
        rd(3'h2, d); check("R10 byte write to cfg", d, 16'h3303);
        wr(3'h6, 16'h0000, 1'b1);
        rd(3'h6, d); check("R10 half write to act", d, 16'h0080);

        // R9 first write wins
        wr(3'h2, 16'h2200, 1'b1);
        wr(3'h2, 16'h0001, 1'b1);
        rd(3'h2, d); check("R9 cfg second write", d, 16'h2200);
        wr(3'h6, 16'h0000, 1'b0);
        wr(3'h6, 16'h0080, 1'b0);
        rd(3'h6, d); check("R9 act second write", d, 16'h0000);

        // R2 broken unlock pattern does not start the counter
        do_reset();
        wr(3'h0, 16'h0000, 1'b0);
        wr(3'h0, 16'h0055, 1'b0);
        wr(3'h0, 16'h00FF, 1'b0);
        repeat (5) @(negedge clk);
        rd(3'h0, d); check("R2 cancelled pattern", d, 16'h0000);
        kick();
        rd(3'h0, d); check("R2 valid pattern loads", d, 16'h00FF);
        // R9 lock after refresh without prior write
        wr(3'h2, 16'h0000, 1'b1);
        rd(3'h2, d); check("R9 cfg frozen by refresh", d, 16'h3303);

        // R5 / R7 window vectors
        for (int i = 0; i < 6; i++) begin
            logic [15:0] gap;
            logic        err;
            logic [7:0]  act;
            gap = VEC[i][31:16];
            err = VEC[i][8];
            act = VEC[i][7:0];
            do_reset();
            wr(3'h2, 16'h2200, 1'b1);
            wr(3'h6, {8'h00, act}, 1'b0);
            kick();
            rd(3'h4, d); check("R5 first refresh no error", d, 16'h0000);
            repeat (int'(gap)) @(negedge clk);
            kick();
            rd(3'h4, d); check("R5 window vector", d, {14'h0, err, 1'b0});
            check("R7 action routing", {14'h0, irq_o, rst_req_o},
                  !err ? 16'h0 : (act[7] ? 16'h1 : 16'h2));
        end

        // R3 4096-tick period with reset action
        do_reset();
        wr(3'h2, 16'h0001, 1'b1);
        kick();
        rd(3'h0, d); check("R3 load value 4095", d, 16'h003F);
        underflow_run("R3 R7 period 4096", 4096, 1'b1);
        // R8 clear only the underflow bit
        wr(3'h4, 16'h0002, 1'b1);
        rd(3'h4, d); check("R8 status cleared", d, 16'h0000);
        check("R8 output dropped", {14'h0, irq_o, rst_req_o}, 16'h0);

        // R4 divide by 4
        do_reset();
        wr(3'h2, 16'h0010, 1'b1);
        wr(3'h6, 16'h0000, 1'b0);
        kick();
        underflow_run("R4 divide by 4", 4096, 1'b0);

        // R4 undefined code acts as divide by 1
        do_reset();
        wr(3'h2, 16'h0070, 1'b1);
        wr(3'h6, 16'h0000, 1'b0);
        kick();
        underflow_run("R4 undefined divider", 1024, 1'b0);
        // R8 writing ones keeps flags
        wr(3'h4, 16'h0003, 1'b1);
        rd(3'h4, d); check("R8 write ones keeps flag", d, 16'h0001);
        // R6 counter stays stopped after underflow
        repeat (10) @(negedge clk);
        rd(3'h0, d); check("R6 counter stopped", d, 16'h0000);

        finish_run();
    end
endmodule